// File: doc/BRIEF.md
# Row Buffer Command Front End

This block is the command front end of a nonvolatile memory that reaches its array through a two-step addressing scheme. Commands arrive on a 10-bit command/address bus. The bus is captured on both clock edges, so one clock cycle carries a full 20-bit command. There are four independent pairs of buffers. Each pair has an address buffer and a 32-byte data buffer.

A PREACTIVE command primes one address buffer with the upper part of a row address. An ACTIVATE command supplies the rest of the row. It then fetches that row from the array into the paired data buffer, using a request/acknowledge port. READ and WRITE commands then move bursts of bytes out of, or into, a valid data buffer. The burst length is 4, 8 or 16 bytes, and a burst wraps inside the 32-byte buffer.

Only one operation runs at a time. While a fetch or a burst is running, the block rejects new commands and flags them. It also flags an ACTIVATE to an address buffer that was never primed, and a READ or WRITE to a data buffer that does not hold valid data.

Top module: `rowbuf_cmd_front`

## Requirements
- R1: The block captures the rising-edge half of a command together with `cs_n` on the rising edge of cycle t, and the falling-edge half on the falling edge of the same cycle. The command takes effect on the next rising edge. The rising half holds these fields: opcode in bits [2:0] (1 PREACTIVE, 2 ACTIVATE, 3 READ, 4 WRITE), buffer select in bits [4:3], and a row field in bits [9:5]. The column is falling-half bits [4:0].
- R2: PREACTIVE stores {rising[9:5], falling[9:0]} as the 15-bit upper row part of the selected address buffer. It also marks the paired data buffer invalid.
- R3: An ACTIVATE to a primed buffer raises `arr_req` with `arr_row` = {stored upper part, rising[9:5]}. Both are held until `arr_ack`. On `arr_ack`, byte j of the data buffer takes `arr_rdata[8j+7:8j]` and the buffer becomes valid.
- R4: An ACTIVATE to an address buffer that has had no PREACTIVE since reset pulses `cmd_err` for one cycle and makes no array request.
- R5: A READ to a valid buffer drives `rd_valid` for consecutive cycles. In beat i, `rd_data` is byte (column + i) mod 32 and `beat_col` gives that index, so the burst wraps at the buffer end.
- R6: A WRITE to a valid buffer drives `wr_ready` for consecutive cycles. Each rising edge with `wr_ready` high stores `wr_data` into byte (column + i) mod 32 of the buffer.
- R7: The burst length is taken from `cfg_bl` when the command takes effect: 00 gives 4 beats, 01 gives 8, and 10 or 11 give 16.
- R8: A READ or WRITE to a data buffer that is not valid pulses `cmd_err` and starts no burst.
- R9: While `busy` is high (a fetch or a burst is running), any PREACTIVE, ACTIVATE, READ or WRITE is ignored and pulses `cmd_err`.
- R10: After reset, no address buffer is primed, no data buffer is valid, and `arr_req`, `rd_valid`, `wr_ready`, `busy` and `cmd_err` are low.
- R11: Opcodes 0, 5, 6 and 7, and any cycle with `cs_n` high, change no buffer and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the CA bus is sampled on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low command select, sampled on the rising edge |
| ca | input | 10 | Double-data-rate command/address bus |
| cfg_bl | input | 2 | Burst length selector |
| arr_req | output | 1 | Row fetch request to the array |
| arr_row | output | 20 | Row address of the fetch |
| arr_ack | input | 1 | Array fetch complete, data valid on arr_rdata |
| arr_rdata | input | 256 | Fetched row, byte j in bits [8j+7:8j] |
| rd_valid | output | 1 | Read burst beat valid |
| rd_data | output | 8 | Read burst byte |
| wr_ready | output | 1 | Write burst beat accepted on the next rising edge |
| wr_data | input | 8 | Write burst byte |
| beat_col | output | 5 | Buffer byte index of the current beat |
| busy | output | 1 | Fetch or burst in progress |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |

## Verification
The assertions check the cycle-level rules on every cycle:
- the fetch request and its row stay stable until acknowledged;
- an unprimed ACTIVATE never reaches the array, and neither an invalid-buffer access nor a command arriving while busy starts any activity without a flag;
- the beat column steps by one modulo 32;
- read and write beats never overlap;
- each burst lasts exactly the length chosen when it started.

Only the bench scenarios can show whether the data is right. That covers whether fetched and written bytes land in the right buffer and byte position and whether later reads return them. It also covers whether a PREACTIVE invalidates only its own pair, and whether ignored commands leave the stored contents untouched.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  localparam int BL_W = 5;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PRE  = 3'd1,
    OP_ACT  = 3'd2,
    OP_RD   = 3'd3,
    OP_WR   = 3'd4
  } op_e;

  function automatic op_e op_of(input logic [2:0] code);
    case (code)
      3'd1:    return OP_PRE;
      3'd2:    return OP_ACT;
      3'd3:    return OP_RD;
      3'd4:    return OP_WR;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic [BL_W-1:0] beats_for(input logic [1:0] cfg);
    case (cfg)
      2'b00:   return BL_W'(4);
      2'b01:   return BL_W'(8);
      default: return BL_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/rbf_ca_capture.sv
module rbf_ca_capture #(
  parameter int CA_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic [CA_W-1:0] ca,
  output logic            cmd_vld,
  output logic [CA_W-1:0] rise_half,
  output logic [CA_W-1:0] fall_half
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_vld   <= 1'b0;
      rise_half <= '0;
    end else begin
      cmd_vld   <= !cs_n;
      rise_half <= ca;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_half <= '0;
    else        fall_half <= ca;
  end

endmodule

// File: rtl/rbf_cmd_decode.sv
module rbf_cmd_decode
  import rbf_pkg::*;
#(
  parameter int CA_W  = 10,
  parameter int SEL_W = 2,
  parameter int COL_W = 5,
  localparam int FLD_LO   = 3 + SEL_W,
  localparam int ROW_LO_W = CA_W - FLD_LO,
  localparam int ROW_HI_W = ROW_LO_W + CA_W
) (
  input  logic                cmd_vld,
  input  logic [CA_W-1:0]     rise_half,
  input  logic [CA_W-1:0]     fall_half,
  output op_e                 op,
  output logic [SEL_W-1:0]    sel,
  output logic [ROW_HI_W-1:0] row_hi,
  output logic [ROW_LO_W-1:0] row_lo,
  output logic [COL_W-1:0]    col
);

  always_comb begin
    op     = cmd_vld ? op_of(rise_half[2:0]) : OP_NONE;
    sel    = rise_half[3 +: SEL_W];
    row_lo = rise_half[CA_W-1:FLD_LO];
    row_hi = {rise_half[CA_W-1:FLD_LO], fall_half};
    col    = fall_half[COL_W-1:0];
  end

endmodule

// File: rtl/rbf_buf_bank.sv
module rbf_buf_bank #(
  parameter int NBUF      = 4,
  parameter int BUF_BYTES = 32,
  parameter int DATA_W    = 8,
  parameter int ROW_HI_W  = 15,
  localparam int SEL_W  = $clog2(NBUF),
  localparam int COL_W  = $clog2(BUF_BYTES),
  localparam int LINE_W = BUF_BYTES * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pre_we,
  input  logic [SEL_W-1:0]    pre_sel,
  input  logic [ROW_HI_W-1:0] pre_hi,
  input  logic                fill_we,
  input  logic [SEL_W-1:0]    fill_sel,
  input  logic [LINE_W-1:0]   fill_line,
  input  logic                byte_we,
  input  logic [SEL_W-1:0]    acc_sel,
  input  logic [COL_W-1:0]    acc_col,
  input  logic [DATA_W-1:0]   byte_wdata,
  output logic [DATA_W-1:0]   byte_rdata,
  input  logic [SEL_W-1:0]    look_sel,
  output logic [ROW_HI_W-1:0] look_hi,
  output logic [NBUF-1:0]     primed_vec,
  output logic [NBUF-1:0]     valid_vec
);

  logic [LINE_W-1:0]   line_w [NBUF];
  logic [ROW_HI_W-1:0] hi_w   [NBUF];

  for (genvar g = 0; g < NBUF; g++) begin : g_pair
    logic                primed_q;
    logic                valid_q;
    logic [ROW_HI_W-1:0] hi_q;
    logic [LINE_W-1:0]   line_q;
    logic                hit_pre, hit_fill, hit_byte;

    assign hit_pre  = pre_we  && (pre_sel  == SEL_W'(g));
    assign hit_fill = fill_we && (fill_sel == SEL_W'(g));
    assign hit_byte = byte_we && (acc_sel  == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        primed_q <= 1'b0;
        valid_q  <= 1'b0;
        hi_q     <= '0;
      end else if (hit_pre) begin
        primed_q <= 1'b1;
        valid_q  <= 1'b0;
        hi_q     <= pre_hi;
      end else if (hit_fill) begin
        valid_q  <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        line_q <= '0;
      else if (hit_fill) line_q <= fill_line;
      else if (hit_byte) line_q[acc_col*DATA_W +: DATA_W] <= byte_wdata;
    end

    assign primed_vec[g] = primed_q;
    assign valid_vec[g]  = valid_q;
    assign hi_w[g]       = hi_q;
    assign line_w[g]     = line_q;
  end

  assign byte_rdata = line_w[acc_sel][acc_col*DATA_W +: DATA_W];
  assign look_hi    = hi_w[look_sel];

endmodule

// File: rtl/rbf_burst_ctl.sv
module rbf_burst_ctl
  import rbf_pkg::*;
#(
  parameter int COL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic [BL_W-1:0]  start_beats,
  output logic             active,
  output logic             is_wr,
  output logic [COL_W-1:0] ptr
);

  logic [BL_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      is_wr  <= 1'b0;
      ptr    <= '0;
      left_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      is_wr  <= start_wr;
      ptr    <= start_col;
      left_q <= start_beats;
    end else if (active) begin
      ptr    <= ptr + COL_W'(1);
      left_q <= left_q - BL_W'(1);
      if (left_q == BL_W'(1)) active <= 1'b0;
    end
  end

endmodule

// File: rtl/rowbuf_cmd_front.sv
module rowbuf_cmd_front
  import rbf_pkg::*;
#(
  parameter int CA_W      = 10,
  parameter int NBUF      = 4,
  parameter int BUF_BYTES = 32,
  parameter int DATA_W    = 8,
  localparam int SEL_W    = $clog2(NBUF),
  localparam int COL_W    = $clog2(BUF_BYTES),
  localparam int ROW_LO_W = CA_W - 3 - SEL_W,
  localparam int ROW_HI_W = ROW_LO_W + CA_W,
  localparam int ROW_W    = ROW_HI_W + ROW_LO_W,
  localparam int LINE_W   = BUF_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [CA_W-1:0]   ca,
  input  logic [1:0]        cfg_bl,
  output logic              arr_req,
  output logic [ROW_W-1:0]  arr_row,
  input  logic              arr_ack,
  input  logic [LINE_W-1:0] arr_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic [COL_W-1:0]  beat_col,
  output logic              busy,
  output logic              cmd_err
);

  logic                cmd_vld;
  logic [CA_W-1:0]     rise_half, fall_half;
  op_e                 op;
  logic [SEL_W-1:0]    sel;
  logic [ROW_HI_W-1:0] row_hi;
  logic [ROW_LO_W-1:0] row_lo;
  logic [COL_W-1:0]    col;
  logic [ROW_HI_W-1:0] look_hi;
  logic [NBUF-1:0]     primed_vec, valid_vec;
  logic                burst_active, burst_wr;
  logic [COL_W-1:0]    burst_ptr;
  logic [SEL_W-1:0]    burst_sel_q, fill_sel_q, acc_sel;
  logic                fill_pend_q;
  logic [ROW_W-1:0]    row_q;
  logic                cmd_err_q;

  // named events, also used by the bound checker
  logic is_cmd, ev_cmd_busy, ev_act_blank, ev_rw_invalid;
  logic do_pre, do_act, start_evt, fill_done;

  rbf_ca_capture #(.CA_W(CA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ca(ca),
    .cmd_vld(cmd_vld), .rise_half(rise_half), .fall_half(fall_half)
  );

  rbf_cmd_decode #(.CA_W(CA_W), .SEL_W(SEL_W), .COL_W(COL_W)) u_dec (
    .cmd_vld(cmd_vld), .rise_half(rise_half), .fall_half(fall_half),
    .op(op), .sel(sel), .row_hi(row_hi), .row_lo(row_lo), .col(col)
  );

  assign busy          = fill_pend_q || burst_active;
  assign is_cmd        = (op != OP_NONE);
  assign ev_cmd_busy   = is_cmd && busy;
  assign ev_act_blank  = !busy && (op == OP_ACT) && !primed_vec[sel];
  assign ev_rw_invalid = !busy && (op == OP_RD || op == OP_WR) && !valid_vec[sel];
  assign do_pre        = !busy && (op == OP_PRE);
  assign do_act        = !busy && (op == OP_ACT) && primed_vec[sel];
  assign start_evt     = !busy && (op == OP_RD || op == OP_WR) && valid_vec[sel];
  assign fill_done     = fill_pend_q && arr_ack;
  assign acc_sel       = burst_active ? burst_sel_q : sel;

  rbf_buf_bank #(
    .NBUF(NBUF), .BUF_BYTES(BUF_BYTES), .DATA_W(DATA_W), .ROW_HI_W(ROW_HI_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .pre_we(do_pre), .pre_sel(sel), .pre_hi(row_hi),
    .fill_we(fill_done), .fill_sel(fill_sel_q), .fill_line(arr_rdata),
    .byte_we(burst_active && burst_wr), .acc_sel(acc_sel), .acc_col(burst_ptr),
    .byte_wdata(wr_data), .byte_rdata(rd_data),
    .look_sel(sel), .look_hi(look_hi),
    .primed_vec(primed_vec), .valid_vec(valid_vec)
  );

  rbf_burst_ctl #(.COL_W(COL_W)) u_burst (
    .clk(clk), .rst_n(rst_n),
    .start(start_evt), .start_wr(op == OP_WR), .start_col(col),
    .start_beats(beats_for(cfg_bl)),
    .active(burst_active), .is_wr(burst_wr), .ptr(burst_ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_pend_q <= 1'b0;
      fill_sel_q  <= '0;
      row_q       <= '0;
      burst_sel_q <= '0;
      cmd_err_q   <= 1'b0;
    end else begin
      cmd_err_q <= ev_cmd_busy || ev_act_blank || ev_rw_invalid;
      if (do_act) begin
        fill_pend_q <= 1'b1;
        fill_sel_q  <= sel;
        row_q       <= {look_hi, row_lo};
      end else if (fill_done) begin
        fill_pend_q <= 1'b0;
      end
      if (start_evt) burst_sel_q <= sel;
    end
  end

  assign arr_req  = fill_pend_q;
  assign arr_row  = row_q;
  assign rd_valid = burst_active && !burst_wr;
  assign wr_ready = burst_active && burst_wr;
  assign beat_col = burst_ptr;
  assign cmd_err  = cmd_err_q;

endmodule

// File: rtl/rbf_front_chk.sv
module rbf_front_chk
  import rbf_pkg::*;
#(
  parameter int ROW_W = 20,
  parameter int COL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arr_req,
  input logic             arr_ack,
  input logic [ROW_W-1:0] arr_row,
  input logic             cmd_err,
  input logic             rd_valid,
  input logic             wr_ready,
  input logic [COL_W-1:0] beat_col,
  input logic             burst_active,
  input logic             ev_act_blank,
  input logic             ev_rw_invalid,
  input logic             ev_cmd_busy,
  input logic             start_evt,
  input logic [1:0]       cfg_bl
);

  logic [BL_W-1:0] beat_cnt, beat_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      beat_exp <= '0;
    end else if (start_evt) begin
      beat_cnt <= '0;
      beat_exp <= beats_for(cfg_bl);
    end else if (burst_active) begin
      beat_cnt <= beat_cnt + BL_W'(1);
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && !arr_ack) |=> (arr_req && $stable(arr_row))); // R3
  AST_BLANK_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act_blank |=> !arr_req); // R4
  AST_BLANK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act_blank |=> cmd_err); // R4
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && $past(burst_active)) |-> (beat_col == $past(beat_col) + COL_W'(1))); // R5
  AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_ready)); // R6
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_active) |-> (beat_cnt == beat_exp)); // R7
  AST_INVALID_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rw_invalid |=> (cmd_err && !rd_valid && !wr_ready)); // R8
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_busy |=> cmd_err); // R9

endmodule

bind rowbuf_cmd_front rbf_front_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arr_req(arr_req), .arr_ack(arr_ack),
  .arr_row(arr_row), .cmd_err(cmd_err), .rd_valid(rd_valid),
  .wr_ready(wr_ready), .beat_col(beat_col), .burst_active(burst_active),
  .ev_act_blank(ev_act_blank), .ev_rw_invalid(ev_rw_invalid),
  .ev_cmd_busy(ev_cmd_busy), .start_evt(start_evt), .cfg_bl(cfg_bl)
);

// File: tb/rowbuf_cmd_front_bench.sv
module rowbuf_cmd_front_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic [9:0]   ca = '0;
  logic [1:0]   cfg_bl = '0;
  logic         arr_req;
  logic [19:0]  arr_row;
  logic         arr_ack = 1'b0;
  logic [255:0] arr_rdata = '0;
  logic         rd_valid;
  logic [7:0]   rd_data;
  logic         wr_ready;
  logic [7:0]   wr_data = '0;
  logic [4:0]   beat_col;
  logic         busy;
  logic         cmd_err;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  bit         m_primed [4];
  bit         m_valid  [4];
  logic [14:0] m_hi    [4];
  logic [7:0] m_data   [4][32];

  always #10 clk = ~clk;

  rowbuf_cmd_front u_rowbuf_cmd_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ca(ca), .cfg_bl(cfg_bl),
    .arr_req(arr_req), .arr_row(arr_row), .arr_ack(arr_ack), .arr_rdata(arr_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_ready(wr_ready), .wr_data(wr_data),
    .beat_col(beat_col), .busy(busy), .cmd_err(cmd_err)
  );

  function automatic logic [7:0] row_byte(input logic [19:0] r, input int j);
    return (r[7:0] ^ r[15:8] ^ {4'h0, r[19:16]}) + 8'(j * 29);
  endfunction

  function automatic int bl_len(input logic [1:0] c);
    return (c == 2'b00) ? 4 : (c == 2'b01) ? 8 : 16;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // array responder: acknowledges three cycles after a request appears
  initial begin
    int lat = 0;
    forever begin
      @(posedge clk); #5;
      arr_ack = 1'b0;
      if (arr_req) begin
        lat++;
        if (lat == 3) begin
          for (int j = 0; j < 32; j++) arr_rdata[8*j +: 8] = row_byte(arr_row, j);
          arr_ack = 1'b1;
          lat = 0;
        end
      end else lat = 0;
    end
  end

  // drive one command; returns at 2 ns after the edge where it takes effect
  task automatic send(input logic [9:0] rise, input logic [9:0] fall, input bit sel_on);
    @(posedge clk); #15;
    cs_n = !sel_on; ca = rise;
    @(posedge clk); #5;
    ca = fall;
    #10;
    cs_n = 1'b1; ca = '0;
    @(posedge clk); #2;
  endtask

  function automatic logic [9:0] mk_rise(input int opc, input int s, input logic [4:0] f);
    return {f, 2'(s), 3'(opc)};
  endfunction

  task automatic wait_idle();
    while (busy) begin @(posedge clk); #2; end
  endtask

  task automatic op_pre(input int s, input logic [14:0] hi);
    send(mk_rise(1, s, hi[14:10]), hi[9:0], 1'b1);
    check(cmd_err == 1'b0, "R2", "pre err", cmd_err, 0);
    m_primed[s] = 1; m_valid[s] = 0; m_hi[s] = hi;
  endtask

  task automatic op_act(input int s, input logic [4:0] lo);
    logic [19:0] row;
    send(mk_rise(2, s, lo), '0, 1'b1);
    if (!m_primed[s]) begin
      check(cmd_err == 1'b1, "R4", "blank act err", cmd_err, 1);
      check(arr_req == 1'b0, "R4", "blank act req", arr_req, 0);
    end else begin
      row = {m_hi[s], lo};
      check(cmd_err == 1'b0, "R3", "act err", cmd_err, 0);
      check(arr_req == 1'b1, "R3", "act req", arr_req, 1);
      check(arr_row == row, "R3", "act row", arr_row, row);
      wait_idle();
      for (int j = 0; j < 32; j++) m_data[s][j] = row_byte(row, j);
      m_valid[s] = 1;
    end
  endtask

  task automatic op_rd(input int s, input logic [4:0] c, input logic [1:0] blc);
    int n;
    cfg_bl = blc;
    send(mk_rise(3, s, 5'(s)), {5'd0, c}, 1'b1);
    if (!m_valid[s]) begin
      check(cmd_err == 1'b1, "R8", "invalid read err", cmd_err, 1);
      check(rd_valid == 1'b0, "R8", "invalid read valid", rd_valid, 0);
      return;
    end
    n = bl_len(blc);
    for (int i = 0; i < n; i++) begin
      logic [4:0] k;
      k = 5'(c + i);
      check(rd_valid == 1'b1, "R5", "read beat valid", rd_valid, 1);
      check(beat_col == k, "R5", "read beat col", beat_col, k);
      check(rd_data == m_data[s][k], "R5", "read byte", rd_data, m_data[s][k]);
      @(posedge clk); #2;
    end
    check(rd_valid == 1'b0, "R7", "read burst end", rd_valid, 0);
  endtask

  task automatic op_wr(input int s, input logic [4:0] c, input logic [1:0] blc);
    int n;
    cfg_bl = blc;
    send(mk_rise(4, s, 5'(s)), {5'd0, c}, 1'b1);
    if (!m_valid[s]) begin
      check(cmd_err == 1'b1, "R8", "invalid write err", cmd_err, 1);
      check(wr_ready == 1'b0, "R8", "invalid write ready", wr_ready, 0);
      return;
    end
    n = bl_len(blc);
    for (int i = 0; i < n; i++) begin
      logic [4:0] k;
      k = 5'(c + i);
      check(wr_ready == 1'b1, "R6", "write beat ready", wr_ready, 1);
      wr_data = 8'($urandom);
      m_data[s][k] = wr_data;
      @(posedge clk); #2;
    end
    check(wr_ready == 1'b0, "R7", "write burst end", wr_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(posedge clk); #2;
    // R10 reset state
    check(busy == 0 && arr_req == 0 && cmd_err == 0, "R10", "reset flags", busy, 0);
    check(rd_valid == 0 && wr_ready == 0, "R10", "reset burst", rd_valid, 0);
    op_rd(0, 5'd0, 2'b00);   // R10: buffer 0 not valid after reset
    op_act(1, 5'd3);         // R4 unprimed activate

    // R1 R2 R3 directed fill, R5 wrap with all lengths
    op_pre(2, 15'h5A3C);
    op_act(2, 5'd17);
    op_rd(2, 5'd30, 2'b00);
    op_rd(2, 5'd28, 2'b01);
    op_rd(2, 5'd20, 2'b11);
    op_wr(2, 5'd29, 2'b10);  // R6 wrap write
    op_rd(2, 5'd24, 2'b10);

    // R9: command while fetch pending
    op_pre(3, 15'h0F0F);
    send(mk_rise(2, 3, 5'd9), '0, 1'b1);
    send(mk_rise(1, 2, 5'd1), 10'h3FF, 1'b1);
    check(cmd_err == 1'b1, "R9", "pre during fetch err", cmd_err, 1);
    wait_idle();
    for (int j = 0; j < 32; j++) m_data[3][j] = row_byte({15'h0F0F, 5'd9}, j);
    m_valid[3] = 1;
    op_rd(2, 5'd0, 2'b10);   // R9: buffer 2 untouched
    op_rd(3, 5'd5, 2'b01);

    // R9: command during a read burst
    cfg_bl = 2'b11;
    send(mk_rise(3, 3, 5'd0), 10'd0, 1'b1);
    send(mk_rise(1, 3, 5'd0), 10'd0, 1'b1);
    check(cmd_err == 1'b1, "R9", "pre during burst err", cmd_err, 1);
    wait_idle();
    op_rd(3, 5'd31, 2'b00);

    // R11: no-op opcodes and deselected commands
    send(mk_rise(0, 2, 5'd0), 10'd0, 1'b1);
    check(cmd_err == 0 && busy == 0, "R11", "opcode 0", cmd_err, 0);
    send(mk_rise(6, 2, 5'd0), 10'd0, 1'b1);
    check(cmd_err == 0 && busy == 0, "R11", "opcode 6", cmd_err, 0);
    send(mk_rise(1, 2, 5'd7), 10'd7, 1'b0);
    check(cmd_err == 0 && busy == 0, "R11", "cs_n high", cmd_err, 0);
    op_rd(2, 5'd8, 2'b01);   // R11: still valid with the same bytes

    // R2: preactive invalidates only its own pair
    op_pre(2, 15'h1111);
    op_rd(2, 5'd0, 2'b00);
    op_rd(3, 5'd0, 2'b00);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int s, kind;
      s = int'($urandom_range(3, 0));
      kind = int'($urandom_range(9, 0));
      if (kind < 2)      op_pre(s, 15'($urandom));
      else if (kind < 4) op_act(s, 5'($urandom));
      else if (kind < 7) op_rd(s, 5'($urandom), 2'($urandom));
      else               op_wr(s, 5'($urandom), 2'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule